// File: doc/BRIEF.md
# Multi-Level Effective Address Modifier

This block turns the address field of a 36-bit instruction word into a final operand address or an immediate value. The machine uses 18-bit addresses. The caller supplies the instruction word with a one-cycle start pulse. It also supplies snapshots of the eight index registers, the two 36-bit accumulator halves and the instruction counter. The block decodes the 6-bit tag of the word and computes the result.

Some tags name a register, and the block adds that register to the address field. Other tags ask for an indirect word. The block reads that word from memory through a request/acknowledge port. An indirect word has the same layout as an instruction, so its tag is decoded again. The chain goes on until a terminal form is reached.

The tally form reads a pointer word, then writes the pointer back with its address and its count stepped in opposite directions. A chain that goes too deep ends with a fault. When the result is ready, it appears with a single-cycle done strobe and stays on the outputs until the next completion.

Top module: `addr_modifier`

## Requirements
- R1: While reset is held and immediately after it, done, memReq, memWe, isImm and fault are 0 and effAddr is 0.
- R2: Field positions use bit 0 as the most significant bit, so word[35] is bit 0. The address field Y is word[35:18]. The tag is word[5:0]. The modifier is tag[5:4] (00 register, 01 register-then-indirect, 10 tally-indirect, 11 indirect-then-register) and the designator is tag[3:0]. With modifier 00 and a register designator, effAddr is (Y + register) mod 2^18, isImm is 0, and no memory access occurs.
- R3: Designator codes map as follows. 0000 is no register (direct; Y itself is the address). 0001 is A upper half (aReg[35:18]). 0010 is Q upper half (qReg[35:18]). 0011 is the instruction counter. 0100 is A lower half (aReg[17:0]). 0101 is Q lower half (qReg[17:0]). 1000 to 1111 select index registers 0 to 7, where index register i is xRegs[18*i+17:18*i].
- R4: Designators 0110 and 0111 are immediate. Under modifier 00 or 01 the result is isImm=1 and effAddr=Y, and no memory access occurs.
- R5: Under modifier 01 with a register designator, the block reads the word at (Y + register) mod 2^18. It then decodes that word's tag again, so chains of any mix of forms, up to the level limit, are followed.
- R6: Under modifier 11, the block reads the word at Y and remembers this first designator. When the chain reaches a modifier-00 word, the result uses that word's Y plus the remembered register, and that word's own designator is ignored. Designators of later modifier-11 words are ignored. If the remembered designator is immediate, the result is isImm=1 with that word's Y.
- R7: Under modifier 10, the block reads the pointer word at Y. In a pointer word, bits 35:18 hold the address, bits 17:6 hold a 12-bit tally and bits 5:0 hold a tag. With pointer designator 1101, effAddr is the old address, and the pointer is written back with address+1 and tally-1. With 1100, effAddr is address-1, and the pointer is written back with address-1 and tally+1. The tag is kept, the address wraps mod 2^18 and the tally wraps mod 2^12. Any other pointer designator gives fault=1 and no write.
- R8: A request that needs more than MAX_LEVELS (default 64) indirect reads ends with fault=1 after exactly MAX_LEVELS reads. A chain of exactly MAX_LEVELS reads completes normally.
- R9: memReq stays high with a stable memAddr and memWe until memAck. done is a one-cycle pulse. The results hold until the next completion. A start pulse while a request is in progress is ignored.
- R10: The opcode bits (word[17:9]) and the indirect flag bit (word[7]) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation on instrWord |
| instrWord | input | 36 | Instruction word |
| xRegs | input | 144 | Eight 18-bit index registers, register i at bits 18*i+17:18*i |
| aReg | input | 36 | A accumulator |
| qReg | input | 36 | Q accumulator |
| icVal | input | 18 | Instruction counter |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 18 | Memory word address |
| memWdata | output | 36 | Write data for pointer write-back |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 36 | Read data, valid with memAck |
| done | output | 1 | One-cycle completion strobe |
| effAddr | output | 18 | Effective address or immediate value |
| isImm | output | 1 | effAddr is an immediate operand |
| fault | output | 1 | Bad pointer designator or level limit exceeded |

## Verification
The assertions check the following on every cycle:
- A pending memory request keeps its address and direction steady until it is acknowledged.
- done never lasts two cycles.
- A pointer write-back is followed at once by done.
- isImm and fault are never both set.

Only the bench scenarios can show the arithmetic and the ordering. These include the register selection and the mod-2^18 wrap, the remembered designator of the indirect-then-register form, the pointer address and tally values written back, and the exact read count at the level limit.

// File: rtl/eam_pkg.sv
package eam_pkg;
  localparam int WORD_W = 36;
  localparam int ADDR_W = 18;
  localparam int TALLY_W = 12;
  localparam int TAG_W = 6;
  localparam int TD_W = 4;
  localparam int NUM_X = 8;

  typedef enum logic [1:0] {
    TM_R  = 2'b00,
    TM_RI = 2'b01,
    TM_IT = 2'b10,
    TM_IR = 2'b11
  } tmod_e;

  localparam logic [TD_W-1:0] TD_NONE   = 4'b0000;
  localparam logic [TD_W-1:0] TD_AU     = 4'b0001;
  localparam logic [TD_W-1:0] TD_QU     = 4'b0010;
  localparam logic [TD_W-1:0] TD_IC     = 4'b0011;
  localparam logic [TD_W-1:0] TD_AL     = 4'b0100;
  localparam logic [TD_W-1:0] TD_QL     = 4'b0101;
  localparam logic [TD_W-1:0] TD_IT_INC = 4'b1101;
  localparam logic [TD_W-1:0] TD_IT_DEC = 4'b1100;

  // control -> datapath strobes
  typedef struct packed {
    logic ldInstr;
    logic ldFetch;
    logic ldWord;
    logic ldFinal;
    logic ldItFinal;
    logic ldFault;
    logic rdReq;
    logic wrReq;
  } ctrl_t;

  // datapath -> control status
  typedef struct packed {
    tmod_e tm;
    logic  tdImm;
    logic  levelFull;
    logic  itFetch;
    logic  itTdOk;
  } stat_t;

  function automatic logic isImmTd(input logic [TD_W-1:0] td);
    return (td == 4'b0110) || (td == 4'b0111);
  endfunction
endpackage

// File: rtl/eam_datapath.sv
module eam_datapath
  import eam_pkg::*;
#(
  parameter int MAX_LEVELS = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrl,
  output stat_t                    stat,
  input  logic [WORD_W-1:0]        instrWord,
  input  logic [NUM_X*ADDR_W-1:0]  xRegs,
  input  logic [WORD_W-1:0]        aReg,
  input  logic [WORD_W-1:0]        qReg,
  input  logic [ADDR_W-1:0]        icVal,
  input  logic [WORD_W-1:0]        memRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [WORD_W-1:0]        memWdata,
  output logic [ADDR_W-1:0]        effAddr,
  output logic                     isImm,
  output logic                     fault
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);
  localparam int HALF_W = WORD_W / 2;

  logic [ADDR_W-1:0] xArr [NUM_X];
  for (genvar i = 0; i < NUM_X; i++) begin : g_xsplit
    assign xArr[i] = xRegs[i*ADDR_W +: ADDR_W];
  end

  // current word fields
  logic [ADDR_W-1:0] curY;
  logic [TAG_W-1:0]  curTag;
  logic [ADDR_W-1:0] fetchAddr;
  logic              itFlag;
  logic [TD_W-1:0]   savedTd;
  logic              irPending;
  logic [LVL_W-1:0]  levelCnt;
  logic [WORD_W-1:0] itWord;
  logic [ADDR_W-1:0] effAddrR;
  logic              isImmR;
  logic              faultR;

  logic unusedInstrBits;
  assign unusedInstrBits = ^instrWord[17:6];

  tmod_e             curTm;
  logic [TD_W-1:0]   curTd;
  logic [TD_W-1:0]   effTd;
  logic [ADDR_W-1:0] regVal;
  logic [ADDR_W-1:0] sumAddr;

  assign curTm = tmod_e'(curTag[5:4]);
  assign curTd = curTag[3:0];
  assign effTd = (curTm == TM_R && irPending) ? savedTd : curTd;

  always_comb begin
    case (effTd)
      TD_AU:   regVal = aReg[WORD_W-1:HALF_W];
      TD_QU:   regVal = qReg[WORD_W-1:HALF_W];
      TD_IC:   regVal = icVal;
      TD_AL:   regVal = aReg[HALF_W-1:0];
      TD_QL:   regVal = qReg[HALF_W-1:0];
      default: regVal = effTd[3] ? xArr[effTd[2:0]] : '0;
    endcase
  end

  assign sumAddr = curY + regVal;

  // pointer word fields and update
  logic [ADDR_W-1:0]  ptrAddr;
  logic [TALLY_W-1:0] ptrTally;
  logic [TAG_W-1:0]   ptrTag;
  logic               ptrInc;
  logic               ptrDec;
  logic [ADDR_W-1:0]  ptrNewAddr;
  logic [TALLY_W-1:0] ptrNewTally;

  assign ptrAddr     = memRdata[WORD_W-1:WORD_W-ADDR_W];
  assign ptrTally    = memRdata[TAG_W+TALLY_W-1:TAG_W];
  assign ptrTag      = memRdata[TAG_W-1:0];
  assign ptrInc      = (ptrTag[3:0] == TD_IT_INC);
  assign ptrDec      = (ptrTag[3:0] == TD_IT_DEC);
  assign ptrNewAddr  = ptrInc ? ptrAddr + 1'b1 : ptrAddr - 1'b1;
  assign ptrNewTally = ptrInc ? ptrTally - 1'b1 : ptrTally + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curY      <= '0;
      curTag    <= '0;
      fetchAddr <= '0;
      itFlag    <= 1'b0;
      savedTd   <= '0;
      irPending <= 1'b0;
      levelCnt  <= '0;
      itWord    <= '0;
      effAddrR  <= '0;
      isImmR    <= 1'b0;
      faultR    <= 1'b0;
    end else begin
      if (ctrl.ldInstr) begin
        curY      <= instrWord[WORD_W-1:WORD_W-ADDR_W];
        curTag    <= instrWord[TAG_W-1:0];
        irPending <= 1'b0;
        levelCnt  <= '0;
        itFlag    <= 1'b0;
      end
      if (ctrl.ldFetch) begin
        fetchAddr <= (curTm == TM_RI) ? sumAddr : curY;
        itFlag    <= (curTm == TM_IT);
        levelCnt  <= levelCnt + 1'b1;
        if (curTm == TM_IR && !irPending) begin
          savedTd   <= curTd;
          irPending <= 1'b1;
        end
      end
      if (ctrl.ldWord) begin
        curY   <= memRdata[WORD_W-1:WORD_W-ADDR_W];
        curTag <= memRdata[TAG_W-1:0];
      end
      if (ctrl.ldFinal) begin
        isImmR   <= isImmTd(effTd);
        effAddrR <= isImmTd(effTd) ? curY : sumAddr;
        faultR   <= 1'b0;
      end
      if (ctrl.ldItFinal) begin
        itWord   <= {ptrNewAddr, ptrNewTally, ptrTag};
        effAddrR <= ptrInc ? ptrAddr : ptrNewAddr;
        isImmR   <= 1'b0;
        faultR   <= 1'b0;
      end
      if (ctrl.ldFault) begin
        effAddrR <= '0;
        isImmR   <= 1'b0;
        faultR   <= 1'b1;
      end
    end
  end

  assign stat.tm        = curTm;
  assign stat.tdImm     = isImmTd(curTd);
  assign stat.levelFull = (levelCnt == LVL_W'(MAX_LEVELS));
  assign stat.itFetch   = itFlag;
  assign stat.itTdOk    = ptrInc || ptrDec;

  assign memAddr  = fetchAddr;
  assign memWdata = itWord;
  assign effAddr  = effAddrR;
  assign isImm    = isImmR;
  assign fault    = faultR;
endmodule

// File: rtl/eam_control.sv
module eam_control
  import eam_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  memAck,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  done
);
  typedef enum logic [2:0] {
    S_IDLE,
    S_DECODE,
    S_FETCH,
    S_WRBACK,
    S_FINISH
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.ldInstr = 1'b1;
          nextState    = S_DECODE;
        end
      end
      S_DECODE: begin
        if (stat.tm == TM_R || (stat.tm == TM_RI && stat.tdImm)) begin
          ctrl.ldFinal = 1'b1;
          nextState    = S_FINISH;
        end else if (stat.levelFull) begin
          ctrl.ldFault = 1'b1;
          nextState    = S_FINISH;
        end else begin
          ctrl.ldFetch = 1'b1;
          nextState    = S_FETCH;
        end
      end
      S_FETCH: begin
        ctrl.rdReq = 1'b1;
        if (memAck) begin
          if (!stat.itFetch) begin
            ctrl.ldWord = 1'b1;
            nextState   = S_DECODE;
          end else if (stat.itTdOk) begin
            ctrl.ldItFinal = 1'b1;
            nextState      = S_WRBACK;
          end else begin
            ctrl.ldFault = 1'b1;
            nextState    = S_FINISH;
          end
        end
      end
      S_WRBACK: begin
        ctrl.wrReq = 1'b1;
        if (memAck) nextState = S_FINISH;
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  assign done = (state == S_FINISH);
endmodule

// File: rtl/addr_modifier.sv
module addr_modifier
  import eam_pkg::*;
#(
  parameter int MAX_LEVELS = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [WORD_W-1:0]       instrWord,
  input  logic [NUM_X*ADDR_W-1:0] xRegs,
  input  logic [WORD_W-1:0]       aReg,
  input  logic [WORD_W-1:0]       qReg,
  input  logic [ADDR_W-1:0]       icVal,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_W-1:0]       memWdata,
  input  logic                    memAck,
  input  logic [WORD_W-1:0]       memRdata,
  output logic                    done,
  output logic [ADDR_W-1:0]       effAddr,
  output logic                    isImm,
  output logic                    fault
);
  ctrl_t ctrl;
  stat_t stat;

  eam_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .memAck (memAck),
    .stat   (stat),
    .ctrl   (ctrl),
    .done   (done)
  );

  eam_datapath #(.MAX_LEVELS(MAX_LEVELS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .stat      (stat),
    .instrWord (instrWord),
    .xRegs     (xRegs),
    .aReg      (aReg),
    .qReg      (qReg),
    .icVal     (icVal),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .effAddr   (effAddr),
    .isImm     (isImm),
    .fault     (fault)
  );

  assign memReq = ctrl.rdReq | ctrl.wrReq;
  assign memWe  = ctrl.wrReq;
endmodule

// File: rtl/eam_chk.sv
module eam_chk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        isImm,
  input logic        fault,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [17:0] memAddr
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  wrback_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> done);

  // R4
  imm_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isImm, fault}));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !memReq && !done);
endmodule

bind addr_modifier eam_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .isImm   (isImm),
  .fault   (fault),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAck  (memAck),
  .memAddr (memAddr)
);

// File: tb/sim_addr_modifier.sv
module sim_addr_modifier;
  localparam int CLK_PERIOD = 10;
  localparam int MAXLV = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [35:0]  instrWord = '0;
  logic [143:0] xRegs;
  logic [35:0]  aReg, qReg;
  logic [17:0]  icVal;
  logic         memReq, memWe, memAck;
  logic [17:0]  memAddr;
  logic [35:0]  memWdata, memRdata;
  logic         done, isImm, fault;
  logic [17:0]  effAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int readCnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_modifier #(.MAX_LEVELS(MAXLV)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .xRegs(xRegs), .aReg(aReg), .qReg(qReg), .icVal(icVal),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .done(done), .effAddr(effAddr), .isImm(isImm), .fault(fault)
  );

  // memory model: 256 words aliased on low address bits, ack one cycle after request
  logic [35:0] mem [256];
  logic        ackR;
  logic        plWe = 1'b0;
  logic [7:0]  plAddr = '0;
  logic [35:0] plData = '0;

  assign memAck   = ackR;
  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      ackR <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      ackR <= memReq && !ackR;
      if (memReq && memWe && ackR) mem[memAddr[7:0]] <= memWdata;
      else if (plWe) mem[plAddr] <= plData;
      if (memReq && !memWe && ackR) readCnt <= readCnt + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [35:0] mkWord(input logic [17:0] y, input logic [1:0] tm,
                                         input logic [3:0] td, input logic [8:0] op,
                                         input logic ind);
    return {y, op, 1'b0, ind, 1'b0, tm, td};
  endfunction

  function automatic logic [17:0] regOf(input logic [3:0] td);
    case (td)
      4'd1: return aReg[35:18];
      4'd2: return qReg[35:18];
      4'd3: return icVal;
      4'd4: return aReg[17:0];
      4'd5: return qReg[17:0];
      default: return td[3] ? xRegs[td[2:0]*18 +: 18] : 18'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [35:0] d);
    @(negedge clk);
    plWe = 1'b1; plAddr = a; plData = d;
    @(negedge clk);
    plWe = 1'b0;
  endtask

  task automatic run(input logic [35:0] w, input logic [17:0] expAddr, input bit expImm,
                     input bit expFault, input int expReads, input string req,
                     input bit interject);
    int base;
    int wait_n;
    logic [17:0] held;
    base = readCnt;
    @(negedge clk);
    instrWord = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
      if (interject && wait_n == 5) begin
        instrWord = mkWord(18'h00001, 2'b00, 4'd0, 9'd0, 1'b0);
        start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(done, {req, " done seen"}, {35'd0, done}, 36'd1);
    check(effAddr == expAddr, {req, " effAddr"}, {18'd0, effAddr}, {18'd0, expAddr});
    check(isImm == expImm && fault == expFault, {req, " isImm/fault"},
          {34'd0, isImm, fault}, {34'd0, expImm, expFault});
    check(readCnt - base == expReads, {req, " read count"}, 36'(readCnt - base),
          36'(expReads));
    held = effAddr;
    @(negedge clk);
    // R9 single-cycle strobe, held result
    check(!done && effAddr == held, "R9 done pulse/hold", {17'd0, done, effAddr},
          {18'd0, held});
  endtask

  initial begin
    logic [17:0] ys [4];
    logic [17:0] e;
    bit im;
    aReg  = {18'h00021, 18'h00042};
    qReg  = {18'h00063, 18'h00084};
    icVal = 18'h000A5;
    for (int i = 0; i < 8; i++) xRegs[i*18 +: 18] = 18'h00100 + 18'(i * 17);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !memReq && !memWe && !isImm && !fault && effAddr == 0,
          "R1 reset state", {30'd0, done, memReq, memWe, isImm, fault, |effAddr}, 36'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !memReq && effAddr == 0, "R1 after reset",
          {17'd0, done, effAddr}, 36'd0);

    // R2 R3 R4 register sweep, wrap included
    ys[0] = 18'h00000; ys[1] = 18'h01234; ys[2] = 18'h3FFF0; ys[3] = 18'h3FFFF;
    for (int yi = 0; yi < 4; yi++) begin
      for (int td = 0; td < 16; td++) begin
        im = (td == 6 || td == 7);
        e  = im ? ys[yi] : ys[yi] + regOf(4'(td));
        run(mkWord(ys[yi], 2'b00, 4'(td), 9'd0, 1'b0), e, im, 1'b0, 0,
            im ? "R4 R immediate" : "R2 R3 register add", 1'b0);
      end
    end

    // R4 immediate under register-then-indirect
    run(mkWord(18'h00555, 2'b01, 4'd7, 9'd0, 1'b0), 18'h00555, 1'b1, 1'b0, 0,
        "R4 RI immediate", 1'b0);

    // R5 single level: Y=0x10 + X0(0x100) -> 0x110
    poke(8'h10, mkWord(18'h02345, 2'b00, 4'd4, 9'd0, 1'b0));
    run(mkWord(18'h00010, 2'b01, 4'd8, 9'd0, 1'b0), 18'h02387, 1'b0, 1'b0, 1,
        "R5 RI one level", 1'b0);

    // R5 chain: 0x20 -> RI Y=0x30+IC -> 0xD5 -> R Y=0x777 + X3
    poke(8'h20, mkWord(18'h00030, 2'b01, 4'd3, 9'd0, 1'b0));
    poke(8'hD5, mkWord(18'h00777, 2'b00, 4'd11, 9'd0, 1'b0));
    run(mkWord(18'h00020, 2'b01, 4'd0, 9'd0, 1'b0), 18'h00777 + regOf(4'd11), 1'b0,
        1'b0, 2, "R5 RI chain", 1'b0);

    // R6 remembered designator X2, later IR and final td ignored
    poke(8'h40, mkWord(18'h00050, 2'b11, 4'd15, 9'd0, 1'b0));
    poke(8'h50, mkWord(18'h00060, 2'b01, 4'd0, 9'd0, 1'b0));
    poke(8'h60, mkWord(18'h01000, 2'b00, 4'd5, 9'd0, 1'b0));
    run(mkWord(18'h00040, 2'b11, 4'd10, 9'd0, 1'b0), 18'h01000 + regOf(4'd10), 1'b0,
        1'b0, 3, "R6 IR chain", 1'b0);

    // R6 remembered immediate designator
    poke(8'h44, mkWord(18'h003A5, 2'b00, 4'd9, 9'd0, 1'b0));
    run(mkWord(18'h00044, 2'b11, 4'd6, 9'd0, 1'b0), 18'h003A5, 1'b1, 1'b0, 1,
        "R6 IR immediate", 1'b0);

    // R7 increment form
    poke(8'h70, {18'h00ABC, 12'h005, 6'b10_1101});
    run(mkWord(18'h00070, 2'b10, 4'd0, 9'd0, 1'b0), 18'h00ABC, 1'b0, 1'b0, 1,
        "R7 IT inc", 1'b0);
    check(mem[8'h70] == {18'h00ABD, 12'h004, 6'b10_1101}, "R7 IT inc writeback",
          mem[8'h70], {18'h00ABD, 12'h004, 6'b10_1101});
    // R7 increment with wraps
    poke(8'h71, {18'h3FFFF, 12'h000, 6'b00_1101});
    run(mkWord(18'h00071, 2'b10, 4'd3, 9'd0, 1'b0), 18'h3FFFF, 1'b0, 1'b0, 1,
        "R7 IT inc wrap", 1'b0);
    check(mem[8'h71] == {18'h00000, 12'hFFF, 6'b00_1101}, "R7 IT wrap writeback",
          mem[8'h71], {18'h00000, 12'hFFF, 6'b00_1101});
    // R7 decrement form
    poke(8'h72, {18'h00200, 12'hFFF, 6'b10_1100});
    run(mkWord(18'h00072, 2'b10, 4'd0, 9'd0, 1'b0), 18'h001FF, 1'b0, 1'b0, 1,
        "R7 IT dec", 1'b0);
    check(mem[8'h72] == {18'h001FF, 12'h000, 6'b10_1100}, "R7 IT dec writeback",
          mem[8'h72], {18'h001FF, 12'h000, 6'b10_1100});
    // R7 bad pointer designator
    poke(8'h73, {18'h00300, 12'h010, 6'b10_0000});
    run(mkWord(18'h00073, 2'b10, 4'd0, 9'd0, 1'b0), 18'h00000, 1'b0, 1'b1, 1,
        "R7 IT bad designator", 1'b0);
    check(mem[8'h73] == {18'h00300, 12'h010, 6'b10_0000}, "R7 no write on fault",
          mem[8'h73], {18'h00300, 12'h010, 6'b10_0000});

    // R8 exactly MAXLV reads completes
    for (int k = 0; k < MAXLV - 1; k++)
      poke(8'(8'h90 + k), mkWord(18'(8'h90 + k + 1), 2'b01, 4'd0, 9'd0, 1'b0));
    poke(8'hCF, mkWord(18'h01234, 2'b00, 4'd0, 9'd0, 1'b0));
    run(mkWord(18'h00090, 2'b01, 4'd0, 9'd0, 1'b0), 18'h01234, 1'b0, 1'b0, MAXLV,
        "R8 limit reached", 1'b0);
    // R8 self loop faults; R9 start while busy ignored
    poke(8'h80, mkWord(18'h00080, 2'b01, 4'd0, 9'd0, 1'b0));
    run(mkWord(18'h00080, 2'b01, 4'd0, 9'd0, 1'b0), 18'h00000, 1'b0, 1'b1, MAXLV,
        "R8 R9 limit exceeded, start ignored", 1'b1);

    // R10 opcode and indirect flag ignored
    run(mkWord(18'h00123, 2'b00, 4'd12, 9'h1FF, 1'b1), 18'h00123 + regOf(4'd12),
        1'b0, 1'b0, 0, "R10 opcode ignored", 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule